// File: doc/BRIEF.md
# Null-Byte Packer for a Keep-Qualified Byte Stream

This block sits in a 16-byte-wide streaming path. Each upstream beat carries a run of valid bytes that starts at byte lane 0 and is marked by a keep mask. Some beats are short, and a few carry no bytes at all. The packer removes the empty lanes. It appends the valid bytes of each new beat directly after the bytes left over from earlier beats. The downstream side therefore sees only full 16-byte beats, except for the beat that closes a packet.

Bytes that do not fill a whole output word wait in a residue store. When a packet ends, everything still held is flushed. Such a flush can need two output beats when the residue and the closing beat together exceed one word. Both ports use the usual valid/ready handshake, so the packer stalls its input whenever its single output register cannot move.

Top module: `axisNullPacker`

## Requirements
- R1: After reset `outValid` is 0 and `inReady` is 1.
- R2: Within each packet, the valid output bytes, read from lane 0 upward and beat by beat, equal the valid input bytes of that packet in arrival order. No byte is lost, duplicated or reordered.
- R3: Every output beat with `outLast` = 0 has `outKeep` = 16'hFFFF.
- R4: An output beat with `outLast` = 1 has a nonzero `outKeep` whose ones form a single run starting at bit 0. No byte of a later packet ever shares a beat with an earlier packet.
- R5: When the residue and the valid bytes of a closing input beat together exceed 16, two output beats result: a full beat with `outLast` = 0, then the remainder with `outLast` = 1.
- R6: An accepted input beat with `inKeep` = 0 and `inLast` = 0 produces no output beat and leaves the residue unchanged.
- R7: An accepted input beat with `inKeep` = 0 and `inLast` = 1 flushes any residue as a closing beat. If the residue is empty, the beat produces no output at all.
- R8: While `outValid` = 1 and `outReady` = 0, `outValid`, `outData`, `outKeep` and `outLast` keep their values into the next cycle.
- R9: `inReady` is 0 while the output beat is stalled (`outValid` = 1, `outReady` = 0) and while the second beat of a two-beat flush is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inData | input | 128 | Input data, byte lane i at bits 8i+7:8i |
| inKeep | input | 16 | Input byte-valid mask, contiguous from bit 0 |
| inLast | input | 1 | Input beat closes a packet |
| inValid | input | 1 | Input beat offered |
| inReady | output | 1 | Packer accepts the input beat |
| outData | output | 128 | Packed output data; null lanes read as zero |
| outKeep | output | 16 | Output byte-valid mask |
| outLast | output | 1 | Output beat closes a packet |
| outValid | output | 1 | Output beat offered |
| outReady | input | 1 | Downstream accepts the output beat |

## Verification
On every cycle the assertions check the shape of the output mask on closing and non-closing beats, the stability of a stalled output beat, the input stall rule, and that an empty non-closing beat leaves the output idle. Only the scenarios can show that bytes come out in the right order and land in the right packet. The same holds for the two-beat flush and for an empty closing beat that flushes or vanishes depending on the residue. For those, the bench replays every accepted byte through a byte-queue reference and compares each output beat under random lengths and random backpressure.

// File: rtl/axisPackPkg.sv
package axisPackPkg;

  // Per-cycle strobes issued by the control to the datapath
  typedef struct packed {
    logic takeIn;       // input beat accepted this cycle
    logic loadMerged;   // output register takes the low word of the merge
    logic loadPend;     // output register takes the pending flush word
    logic resFromHigh;  // residue takes the high word of the merge
    logic resFromLow;   // residue takes the low word of the merge
    logic resClear;     // residue emptied (packet closed)
    logic pendFromHigh; // pending flush word takes the high word of the merge
  } packStrobeT;

endpackage

// File: rtl/packCtrl.sv
module packCtrl
  import axisPackPkg::*;
#(
  parameter int NB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NB-1:0]     inKeep,
  input  logic              inLast,
  input  logic              inValid,
  output logic              inReady,
  output logic              outValid,
  output logic [NB-1:0]     outKeep,
  output logic              outLast,
  input  logic              outReady,
  output logic [$clog2(NB+1)-1:0] resCnt,
  output packStrobeT        strobe
);

  localparam int CW = $clog2(NB + 1);
  localparam logic [CW:0] NB_W = (CW + 1)'(NB);

  function automatic logic [NB-1:0] lowMask(input logic [CW:0] n);
    logic [NB-1:0] m;
    for (int i = 0; i < NB; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  logic [CW-1:0] inCnt;
  logic [CW:0]   total;
  logic          outFree;
  logic          pendValid;
  logic [CW-1:0] pendCnt;

  always_comb begin
    inCnt = '0;
    for (int i = 0; i < NB; i++) inCnt = inCnt + CW'(inKeep[i]);
  end

  assign total   = {1'b0, resCnt} + {1'b0, inCnt};
  assign outFree = !outValid || outReady;
  assign inReady = !pendValid && outFree;

  always_comb begin
    strobe = '0;
    if (pendValid && outFree) begin
      strobe.loadPend = 1'b1;
    end else if (inValid && inReady) begin
      strobe.takeIn = 1'b1;
      if (!inLast) begin
        if (total >= NB_W) begin
          strobe.loadMerged  = 1'b1;
          strobe.resFromHigh = 1'b1;
        end else begin
          strobe.resFromLow = 1'b1;
        end
      end else if (total != '0) begin
        strobe.loadMerged = 1'b1;
        strobe.resClear   = 1'b1;
        if (total > NB_W) strobe.pendFromHigh = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outKeep   <= '0;
      outLast   <= 1'b0;
      resCnt    <= '0;
      pendValid <= 1'b0;
      pendCnt   <= '0;
    end else begin
      if (strobe.loadPend) begin
        outValid  <= 1'b1;
        outKeep   <= lowMask({1'b0, pendCnt});
        outLast   <= 1'b1;
        pendValid <= 1'b0;
      end else if (strobe.loadMerged) begin
        outValid <= 1'b1;
        outLast  <= inLast && (total <= NB_W);
        outKeep  <= (inLast && (total <= NB_W)) ? lowMask(total) : '1;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
      if (strobe.resFromHigh) resCnt <= CW'(total - NB_W);
      else if (strobe.resFromLow) resCnt <= CW'(total);
      else if (strobe.resClear) resCnt <= '0;
      if (strobe.pendFromHigh) begin
        pendValid <= 1'b1;
        pendCnt   <= CW'(total - NB_W);
      end
    end
  end

endmodule

// File: rtl/packData.sv
module packData
  import axisPackPkg::*;
#(
  parameter int NB = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NB*8-1:0]         inData,
  input  logic [NB-1:0]           inKeep,
  input  logic [$clog2(NB+1)-1:0] resCnt,
  input  packStrobeT              strobe,
  output logic [NB*8-1:0]         outData
);

  localparam int DW = NB * 8;

  logic [DW-1:0]   inMasked;
  logic [DW-1:0]   resData;
  logic [DW-1:0]   pendData;
  logic [2*DW-1:0] merged;

  for (genvar g = 0; g < NB; g++) begin : gLane
    assign inMasked[g*8 +: 8] = inKeep[g] ? inData[g*8 +: 8] : 8'h00;
  end

  // residue lanes above resCnt are kept at zero, so OR joins the two runs
  assign merged = {{DW{1'b0}}, resData} | ({{DW{1'b0}}, inMasked} << {resCnt, 3'b000});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData  <= '0;
      pendData <= '0;
      outData  <= '0;
    end else begin
      if (strobe.loadPend)        outData <= pendData;
      else if (strobe.loadMerged) outData <= merged[DW-1:0];
      if (strobe.resFromHigh)     resData <= merged[2*DW-1:DW];
      else if (strobe.resFromLow) resData <= merged[DW-1:0];
      else if (strobe.resClear)   resData <= '0;
      if (strobe.pendFromHigh)    pendData <= merged[2*DW-1:DW];
    end
  end

endmodule

// File: rtl/axisNullPacker.sv
module axisNullPacker
  import axisPackPkg::*;
#(
  parameter int DATA_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DATA_BYTES*8-1:0] inData,
  input  logic [DATA_BYTES-1:0]   inKeep,
  input  logic                    inLast,
  input  logic                    inValid,
  output logic                    inReady,
  output logic [DATA_BYTES*8-1:0] outData,
  output logic [DATA_BYTES-1:0]   outKeep,
  output logic                    outLast,
  output logic                    outValid,
  input  logic                    outReady
);

  localparam int CW = $clog2(DATA_BYTES + 1);

  packStrobeT    strobe;
  logic [CW-1:0] resCnt;

  packCtrl #(.NB(DATA_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .inKeep(inKeep), .inLast(inLast), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outKeep(outKeep), .outLast(outLast), .outReady(outReady),
    .resCnt(resCnt), .strobe(strobe)
  );

  packData #(.NB(DATA_BYTES)) uData (
    .clk(clk), .rstN(rstN),
    .inData(inData), .inKeep(inKeep), .resCnt(resCnt),
    .strobe(strobe), .outData(outData)
  );

endmodule

// File: rtl/axisNullPackerChk.sv
module axisNullPackerChk #(
  parameter int DATA_BYTES = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [DATA_BYTES-1:0]   inKeep,
  input logic                    inLast,
  input logic                    inValid,
  input logic                    inReady,
  input logic [DATA_BYTES*8-1:0] outData,
  input logic [DATA_BYTES-1:0]   outKeep,
  input logic                    outLast,
  input logic                    outValid,
  input logic                    outReady
);

  // R3: non-closing beats are always full
  a_r3_full_beat: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outLast |-> &outKeep);

  // R4: closing beat mask is nonzero and one run from bit 0
  a_r4_last_contig: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outLast |-> (outKeep != '0) && ((outKeep & (outKeep + 1'b1)) == '0));

  // R8: a stalled beat holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outKeep) && $stable(outLast));

  // R9: no input accepted while the output is stalled
  a_r9_stall_in: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady);

  // R6: an empty non-closing beat into an idle output produces nothing
  a_r6_empty_drop: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && (inKeep == '0) && !inLast && !outValid |=> !outValid);

endmodule

bind axisNullPacker axisNullPackerChk #(.DATA_BYTES(DATA_BYTES)) uChk (
  .clk(clk), .rstN(rstN), .inKeep(inKeep), .inLast(inLast), .inValid(inValid),
  .inReady(inReady), .outData(outData), .outKeep(outKeep), .outLast(outLast),
  .outValid(outValid), .outReady(outReady)
);

// File: tb/axisNullPacker_test.sv
module axisNullPacker_test;

  localparam int NB = 16;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [NB*8-1:0] d;
    logic [NB-1:0]   k;
    logic            l;
  } beatT;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NB*8-1:0] inData = '0;
  logic [NB-1:0]   inKeep = '0;
  logic            inLast = 1'b0;
  logic            inValid = 1'b0;
  logic            inReady;
  logic [NB*8-1:0] outData;
  logic [NB-1:0]   outKeep;
  logic            outLast;
  logic            outValid;
  logic            outReady = 1'b1;

  axisNullPacker #(.DATA_BYTES(NB)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  beatT       stimQ[$];
  beatT       expQ[$];
  logic [7:0] byteQ[$];
  int         checks = 0;
  int         fails = 0;
  bit         lastFired = 0;
  bit         prevStall = 0;
  beatT       stallBeat;
  bit         done = 0;

  function automatic logic [NB-1:0] lowMask(input int n);
    logic [NB-1:0] m;
    for (int i = 0; i < NB; i++) m[i] = (i < n);
    return m;
  endfunction

  function automatic beatT mkBeat(input int n, input bit last);
    beatT b;
    for (int i = 0; i < NB / 4; i++) b.d[i*32 +: 32] = $urandom;
    b.k = lowMask(n);
    b.l = last;
    return b;
  endfunction

  function automatic logic [NB*8-1:0] maskData(input logic [NB*8-1:0] d, input logic [NB-1:0] k);
    logic [NB*8-1:0] r;
    for (int i = 0; i < NB; i++) r[i*8 +: 8] = k[i] ? d[i*8 +: 8] : 8'h00;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [NB*8-1:0] act, input logic [NB*8-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Byte-queue reference: gather accepted bytes, cut into beats
  task automatic modelAccept(input beatT b);
    for (int i = 0; i < NB; i++) if (b.k[i]) byteQ.push_back(b.d[i*8 +: 8]);
    if (!b.l) begin
      while (byteQ.size() >= NB) begin
        beatT e;
        e.d = '0;
        for (int i = 0; i < NB; i++) e.d[i*8 +: 8] = byteQ.pop_front();
        e.k = '1; e.l = 1'b0;
        expQ.push_back(e);
      end
    end else begin
      while (byteQ.size() > 0) begin
        beatT e;
        int n;
        n = (byteQ.size() > NB) ? NB : byteQ.size();
        e.d = '0;
        for (int i = 0; i < n; i++) e.d[i*8 +: 8] = byteQ.pop_front();
        e.k = lowMask(n);
        e.l = (byteQ.size() == 0);
        expQ.push_back(e);
      end
    end
  endtask

  task automatic step(input bit randReady);
    @(negedge clk);
    if (!inValid || lastFired) begin
      if (stimQ.size() > 0) begin
        beatT b;
        b = stimQ.pop_front();
        inData = b.d; inKeep = b.k; inLast = b.l; inValid = 1'b1;
      end else begin
        inValid = 1'b0;
      end
    end
    outReady = randReady ? ($urandom % 4 != 0) : 1'b1;
    #1;
    if (prevStall)  // R8
      check(outValid && outData == stallBeat.d && outKeep == stallBeat.k && outLast == stallBeat.l,
            "R8", "stalled beat changed", outData, stallBeat.d);
    prevStall = 0;
    if (outValid && !outReady) begin
      check(!inReady, "R9", "inReady during stall", {127'b0, inReady}, '0);
      prevStall = 1;
      stallBeat.d = outData; stallBeat.k = outKeep; stallBeat.l = outLast;
    end
    lastFired = inValid && inReady;
    if (lastFired) begin
      beatT a;
      a.d = inData; a.k = inKeep; a.l = inLast;
      modelAccept(a);
    end
    if (outValid && outReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2", "unexpected output beat", outData, '0);
      end else begin
        beatT e;
        e = expQ.pop_front();
        check(maskData(outData, outKeep) == e.d, "R2", "data", outData, e.d);
        check(outKeep == e.k, e.l ? "R4" : "R3", "keep", {112'b0, outKeep}, {112'b0, e.k});
        check(outLast == e.l, "R4/R5", "last", {127'b0, outLast}, {127'b0, e.l});
      end
    end
  endtask

  task automatic runAll(input bit randReady, input int extra);
    int guard = 0;
    while ((stimQ.size() > 0 || (inValid && !lastFired) || expQ.size() > 0) && guard < 100000) begin
      step(randReady);
      guard++;
    end
    for (int i = 0; i < extra; i++) step(randReady);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(outValid == 1'b0, "R1", "outValid after reset", {127'b0, outValid}, '0);
    check(inReady == 1'b1, "R1", "inReady after reset", {127'b0, inReady}, {127'b0, 1'b1});

    // R6: empty non-closing beat gives nothing
    stimQ.push_back(mkBeat(0, 0));
    runAll(0, 3);
    check(outValid == 1'b0, "R6", "empty beat produced output", {127'b0, outValid}, '0);

    // R7: empty closing beat flushes residue of 5 bytes
    stimQ.push_back(mkBeat(5, 0));
    stimQ.push_back(mkBeat(0, 1));
    runAll(0, 2);
    // R7: empty closing beat with empty residue vanishes
    stimQ.push_back(mkBeat(0, 1));
    runAll(0, 3);
    check(outValid == 1'b0, "R7", "empty close on empty residue", {127'b0, outValid}, '0);

    // R5: 10 + 12 bytes close as two beats
    stimQ.push_back(mkBeat(10, 0));
    stimQ.push_back(mkBeat(12, 1));
    runAll(0, 2);

    // full beats pass straight through; 15 + 16 + 1 with a close
    stimQ.push_back(mkBeat(16, 0));
    stimQ.push_back(mkBeat(16, 1));
    stimQ.push_back(mkBeat(15, 0));
    stimQ.push_back(mkBeat(16, 0));
    stimQ.push_back(mkBeat(1, 1));
    stimQ.push_back(mkBeat(15, 0));
    stimQ.push_back(mkBeat(16, 1));
    runAll(0, 2);

    // random lengths and closes under random backpressure
    for (int i = 0; i < 4000; i++) begin
      int n;
      n = ($urandom % 4 == 0) ? NB : int'($urandom % (NB + 1));
      stimQ.push_back(mkBeat(n, $urandom % 6 == 0));
    end
    runAll(1, 0);
    runAll(0, 4);
    check(expQ.size() == 0, "R2", "beats missing at end", 128'(expQ.size()), '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule